// File: doc/BRIEF.md
# Variable Block Size SAD Tree

This block computes sums of absolute differences between a 16×16 current macroblock and a 16×16 reference candidate. It returns them for whichever H.264 partition shape is chosen. One full 16-pixel row of current and reference pixels arrives per valid cycle. Four identical 4×4 units work side by side, one per 4-pixel column group. Each unit builds the SAD of one 4×4 sub-block over four rows. The sub-blocks are numbered 0 to 15 in raster order, so every four rows form one loading stage that covers sub-blocks 4s to 4s+3.

A merge stage keeps per-column sums across stages. It adds the 4×4 results into the SAD of each partition of the selected shape as soon as that partition's bottom row of sub-blocks is finished. Results leave on four output lanes. Each lane carries a SAD, a partition index and a valid flag that pulses once per completed partition, ready for a downstream minimum comparator.

Top module: `vbs_sad_tree`

## Requirements
- R1: Pixels are 8-bit unsigned. The SAD of a 4×4 sub-block is the sum of its 16 values |cur − ref|, with a maximum of 4080. Pixel column x of a row sits at bits [8x+7:8x] of `cur_row` and `ref_row`.
- R2: Valid row k of a macroblock (k = 0..15) is pixel row k. Sub-block b covers rows 4·(b/4)..4·(b/4)+3 and columns 4·(b%4)..4·(b%4)+3. Stage s is rows 4s..4s+3.
- R3: `in_shape` encodes width×height as 0=16×16, 1=16×8, 2=8×16, 3=8×8, 4=8×4, 5=4×8, 6=4×4, 7=4×4. A partition's index is its raster position in that shape's partition grid, counted row by row from 0.
- R4: A partition's result is valid on the outputs exactly one cycle after the edge that captures unit completion. That edge is the one following the edge that samples the last row of the stage holding the partition's bottom sub-blocks. The valid flag is high for that single cycle only.
- R5: Partitions completing at the same stage occupy lanes 0, 1, ... in ascending index order. All other lanes are invalid.
- R6: A stage emits only those partitions whose bottom sub-block row equals that stage. A 4×4 or 8×4 shape emits at every stage, a 16×8, 8×8 or 4×8 shape emits at stages 1 and 3, and a 16×16 or 8×16 shape emits at stage 3 only.
- R7: A 16×16 SAD is given in full 16-bit width, up to 65280, without wrap.
- R8: A cycle with `in_valid` low is ignored, including its `in_start`, `in_shape` and pixels. Rows need not be contiguous.
- R9: A valid row with `in_start` high is row 0 of a new macroblock and loads the shape. Any partly received macroblock is dropped. After row 15, rows continue as a new macroblock with the held shape.
- R10: `in_shape` on valid rows without `in_start` has no effect.
- R11: While reset is asserted, and in the cycle after it is released, all output valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row present this cycle |
| in_start | input | 1 | Row is row 0 of a new macroblock |
| in_shape | input | 3 | Partition shape code, taken on start rows |
| cur_row | input | 128 | Sixteen current pixels, column x at [8x+7:8x] |
| ref_row | input | 128 | Sixteen reference pixels, same layout |
| out_valid | output | 4 | Per-lane result valid pulse |
| out_sad | output | 64 | Per-lane SAD, lane l at [16l+15:16l] |
| out_idx | output | 16 | Per-lane partition index, lane l at [4l+3:4l] |

## Verification
A wrong row counter or stage register shifts results to the wrong stage. That shows at the ports as a valid pulse missing or extra one cycle after a stage end, and the every-clock comparison flags it at once. A column accumulator that fails to clear, or clears too early, corrupts the SAD of the next 4×8, 8×8, 8×16, 16×8 or 16×16 partition. The error appears within two stages. A bad shape latch shows as wrong lane counts or indices at the first stage end of the affected macroblock.

// File: rtl/vbs_sad_pkg.sv
package vbs_sad_pkg;
    localparam int PIX_W    = 8;
    localparam int LANES    = 4;
    localparam int UNIT_PIX = 4;
    localparam int SUB_W    = 12;
    localparam int PAIR_W   = SUB_W + 1;
    localparam int FULL_W   = SUB_W + 2;
    localparam int OUT_W    = 16;
    localparam int IDX_W    = 4;

    typedef enum logic [2:0] {
        SH_16X16 = 3'd0,
        SH_16X8  = 3'd1,
        SH_8X16  = 3'd2,
        SH_8X8   = 3'd3,
        SH_8X4   = 3'd4,
        SH_4X8   = 3'd5,
        SH_4X4   = 3'd6,
        SH_4X4B  = 3'd7
    } shape_e;
endpackage

// File: rtl/sad4_unit.sv
module sad4_unit
    import vbs_sad_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int NP = UNIT_PIX,
    parameter int AW = SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_valid,
    input  logic             row_first,
    input  logic             row_last,
    input  logic [NP*PW-1:0] cur_px,
    input  logic [NP*PW-1:0] ref_px,
    output logic [AW-1:0]    sad,
    output logic             done
);
    localparam int RS_W = PW + $clog2(NP);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          done;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic [RS_W-1:0] row_sum;

    always_comb begin
        row_sum = '0;
        for (int k = 0; k < NP; k++) begin
            logic [PW-1:0] a, b;
            a = cur_px[k*PW +: PW];
            b = ref_px[k*PW +: PW];
            row_sum = row_sum + RS_W'((a > b) ? (a - b) : (b - a));
        end
        st_d      = st_q;
        st_d.done = 1'b0;
        if (row_valid) begin
            st_d.acc  = (row_first ? '0 : st_q.acc) + AW'(row_sum);
            st_d.done = row_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sad  = st_q.acc;
    assign done = st_q.done;

    // R1: a completed 4x4 sum never exceeds sixteen maximal differences
    p_sad_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sad <= AW'(NP * NP * ((1 << PW) - 1))));
endmodule

// File: rtl/sad_merge.sv
module sad_merge
    import vbs_sad_pkg::*;
#(
    parameter int NL = LANES,
    parameter int SW = SUB_W,
    parameter int PW2 = PAIR_W,
    parameter int FW = FULL_W,
    parameter int OW = OUT_W,
    parameter int IW = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_done,
    input  logic [1:0]       blk_stage,
    input  shape_e           blk_shape,
    input  logic [NL*SW-1:0] unit_sad,
    output logic [NL-1:0]    res_valid,
    output logic [NL*OW-1:0] res_sad,
    output logic [NL*IW-1:0] res_idx
);
    typedef struct packed {
        logic [NL-1:0][PW2-1:0] colpair;
        logic [NL-1:0][FW-1:0]  colfull;
        logic [NL-1:0]          ov;
        logic [NL-1:0][OW-1:0]  osad;
        logic [NL-1:0][IW-1:0]  oidx;
    } mrg_st_t;

    mrg_st_t st_d, st_q;
    logic [NL-1:0][SW-1:0]  u;
    logic [NL-1:0][PW2-1:0] pair_n;
    logic [NL-1:0][FW-1:0]  full_n;

    always_comb begin
        for (int c = 0; c < NL; c++) begin
            u[c]      = unit_sad[c*SW +: SW];
            pair_n[c] = (blk_stage[0] ? st_q.colpair[c] : '0) + PW2'(u[c]);
            full_n[c] = ((blk_stage != 2'd0) ? st_q.colfull[c] : '0) + FW'(u[c]);
        end
        st_d    = st_q;
        st_d.ov = '0;
        if (blk_done) begin
            st_d.colpair = pair_n;
            st_d.colfull = full_n;
            unique case (blk_shape)
                SH_4X4, SH_4X4B: begin
                    for (int c = 0; c < NL; c++) begin
                        st_d.ov[c]   = 1'b1;
                        st_d.osad[c] = OW'(u[c]);
                        st_d.oidx[c] = {blk_stage, 2'(c)};
                    end
                end
                SH_8X4: begin
                    for (int l = 0; l < 2; l++) begin
                        st_d.ov[l]   = 1'b1;
                        st_d.osad[l] = OW'(u[2*l]) + OW'(u[2*l+1]);
                        st_d.oidx[l] = {1'b0, blk_stage, 1'(l)};
                    end
                end
                SH_4X8: begin
                    if (blk_stage[0]) begin
                        for (int c = 0; c < NL; c++) begin
                            st_d.ov[c]   = 1'b1;
                            st_d.osad[c] = OW'(pair_n[c]);
                            st_d.oidx[c] = {1'b0, blk_stage[1], 2'(c)};
                        end
                    end
                end
                SH_8X8: begin
                    if (blk_stage[0]) begin
                        for (int l = 0; l < 2; l++) begin
                            st_d.ov[l]   = 1'b1;
                            st_d.osad[l] = OW'(pair_n[2*l]) + OW'(pair_n[2*l+1]);
                            st_d.oidx[l] = {2'b00, blk_stage[1], 1'(l)};
                        end
                    end
                end
                SH_16X8: begin
                    if (blk_stage[0]) begin
                        st_d.ov[0]   = 1'b1;
                        st_d.osad[0] = OW'(pair_n[0]) + OW'(pair_n[1])
                                     + OW'(pair_n[2]) + OW'(pair_n[3]);
                        st_d.oidx[0] = {3'b000, blk_stage[1]};
                    end
                end
                SH_8X16: begin
                    if (blk_stage == 2'd3) begin
                        for (int l = 0; l < 2; l++) begin
                            st_d.ov[l]   = 1'b1;
                            st_d.osad[l] = OW'(full_n[2*l]) + OW'(full_n[2*l+1]);
                            st_d.oidx[l] = IW'(l);
                        end
                    end
                end
                default: begin
                    if (blk_stage == 2'd3) begin
                        st_d.ov[0]   = 1'b1;
                        st_d.osad[0] = OW'(full_n[0]) + OW'(full_n[1])
                                     + OW'(full_n[2]) + OW'(full_n[3]);
                        st_d.oidx[0] = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.ov;
    assign res_sad   = st_q.osad;
    assign res_idx   = st_q.oidx;

    // R5: lanes fill from lane 0 upward without holes
    p_lane_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid[1] |-> res_valid[0]);
    p_lane_fill_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid[3] |-> (res_valid[2] && res_valid[1]));
    // R5: neighbouring lanes carry consecutive indices
    p_lane_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid[1] |-> (res_idx[2*IW-1:IW] == res_idx[IW-1:0] + IW'(1)));
    // R6: results only follow a completed stage
    p_out_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid != '0) |-> $past(blk_done));
endmodule

// File: rtl/vbs_sad_tree.sv
module vbs_sad_tree
    import vbs_sad_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int NL = LANES,
    parameter int OW = OUT_W,
    parameter int IW = IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_start,
    input  logic [2:0]         in_shape,
    input  logic [16*PW-1:0]   cur_row,
    input  logic [16*PW-1:0]   ref_row,
    output logic [NL-1:0]      out_valid,
    output logic [NL*OW-1:0]   out_sad,
    output logic [NL*IW-1:0]   out_idx
);
    localparam int NP     = 16 / NL;
    localparam int ROWS   = 16;
    localparam int ROW_W  = $clog2(ROWS);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        shape_e           shape;
        logic [1:0]       dstage;
        shape_e           dshape;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [ROW_W-1:0] row_eff;
    shape_e           shape_eff;
    logic [NL-1:0]    unit_done;
    logic [NL*SUB_W-1:0] unit_sad;
    logic             all_done;

    always_comb begin
        row_eff   = in_start ? '0 : st_q.row;
        shape_eff = in_start ? shape_e'(in_shape) : st_q.shape;
        st_d      = st_q;
        if (in_valid) begin
            st_d.row   = row_eff + ROW_W'(1);
            st_d.shape = shape_eff;
            if (row_eff[1:0] == 2'd3) begin
                st_d.dstage = row_eff[3:2];
                st_d.dshape = shape_eff;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{row: '0, shape: SH_16X16, dstage: 2'd0, dshape: SH_16X16};
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NL; g++) begin : g_unit
        sad4_unit #(.PW(PW), .NP(NP), .AW(SUB_W)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .row_valid (in_valid),
            .row_first (row_eff[1:0] == 2'd0),
            .row_last  (row_eff[1:0] == 2'd3),
            .cur_px    (cur_row[g*NP*PW +: NP*PW]),
            .ref_px    (ref_row[g*NP*PW +: NP*PW]),
            .sad       (unit_sad[g*SUB_W +: SUB_W]),
            .done      (unit_done[g])
        );
    end

    assign all_done = &unit_done;

    sad_merge #(.NL(NL), .SW(SUB_W), .PW2(PAIR_W), .FW(FULL_W), .OW(OW), .IW(IW)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_done  (all_done),
        .blk_stage (st_q.dstage),
        .blk_shape (st_q.dshape),
        .unit_sad  (unit_sad),
        .res_valid (out_valid),
        .res_sad   (out_sad),
        .res_idx   (out_idx)
    );

    // R4: a stage needs four rows, so completions never come back to back
    p_done_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |=> !all_done);
    // R8: an idle input cycle leaves the row position unchanged
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.row));
    // R2: units finish together
    p_units_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done == '0) || (unit_done == '1));
endmodule

// File: tb/vbs_sad_tree_tb.sv
module vbs_sad_tree_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_start = 1'b0;
    logic [2:0]   in_shape = 3'd0;
    logic [127:0] cur_row = '0;
    logic [127:0] ref_row = '0;
    logic [3:0]   out_valid;
    logic [63:0]  out_sad;
    logic [15:0]  out_idx;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R11";
    int max16 = -1;

    always #2 clk = ~clk;

    vbs_sad_tree u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_shape(in_shape), .cur_row(cur_row), .ref_row(ref_row),
        .out_valid(out_valid), .out_sad(out_sad), .out_idx(out_idx)
    );

    // behavioural reference model
    int blk[16];
    int mrow = 0;
    int mshape = 0;
    bit e1v[4], e2v[4];
    int e1s[4], e2s[4], e1i[4], e2i[4];

    always @(posedge clk) begin
        for (int l = 0; l < 4; l++) begin
            e2v[l] = e1v[l]; e2s[l] = e1s[l]; e2i[l] = e1i[l];
            e1v[l] = 1'b0;   e1s[l] = 0;      e1i[l] = 0;
        end
        if (!rst_n) begin
            mrow = 0; mshape = 0;
            for (int b = 0; b < 16; b++) blk[b] = 0;
        end else if (in_valid) begin
            int r, s, w, h, lane;
            r = in_start ? 0 : mrow;
            if (in_start) mshape = in_shape;
            s = r / 4;
            for (int b = 0; b < 4; b++) begin
                int acc;
                acc = 0;
                for (int x = 4*b; x < 4*b+4; x++) begin
                    int a, c;
                    a = cur_row[8*x +: 8];
                    c = ref_row[8*x +: 8];
                    acc += (a > c) ? a - c : c - a;
                end
                if (r % 4 == 0) blk[4*s+b] = 0;
                blk[4*s+b] += acc;
            end
            if (r % 4 == 3) begin
                case (mshape)
                    0: begin w = 4; h = 4; end
                    1: begin w = 4; h = 2; end
                    2: begin w = 2; h = 4; end
                    3: begin w = 2; h = 2; end
                    4: begin w = 2; h = 1; end
                    5: begin w = 1; h = 2; end
                    default: begin w = 1; h = 1; end
                endcase
                lane = 0;
                for (int py = 0; py < 4 / h; py++)
                    for (int px = 0; px < 4 / w; px++)
                        if (py*h + h - 1 == s) begin
                            int sum;
                            sum = 0;
                            for (int by = py*h; by < py*h + h; by++)
                                for (int bx = px*w; bx < px*w + w; bx++)
                                    sum += blk[4*by + bx];
                            e1v[lane] = 1'b1;
                            e1s[lane] = sum;
                            e1i[lane] = py * (4 / w) + px;
                            lane++;
                        end
            end
            mrow = (r + 1) % 16;
        end
    end

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            for (int l = 0; l < 4; l++) begin
                tests++;
                if (out_valid[l] !== e2v[l]) begin
                    fails++;
                    $display("FAIL %s/R4/R5/R6 lane %0d valid actual %0b expected %0b",
                             cur_req, l, out_valid[l], e2v[l]);
                end else if (e2v[l]) begin
                    tests++;
                    if (out_sad[16*l +: 16] !== 16'(e2s[l]) || out_idx[4*l +: 4] !== 4'(e2i[l])) begin
                        fails++;
                        $display("FAIL %s/R3 lane %0d sad/idx actual %0d/%0d expected %0d/%0d",
                                 cur_req, l, out_sad[16*l +: 16], out_idx[4*l +: 4], e2s[l], e2i[l]);
                    end
                end
            end
            if (out_valid[0] && cur_req == "R7") max16 = out_sad[15:0];
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic drive(bit v, bit st, logic [2:0] sh, logic [127:0] c, logic [127:0] r);
        in_valid = v; in_start = st; in_shape = sh; cur_row = c; ref_row = r;
        @(negedge clk);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // mode 0 random, 1 maximal difference, 2 identical pixels
    task automatic send_mb(int shape, int mode, bit gaps, int nrows);
        for (int k = 0; k < nrows; k++) begin
            logic [127:0] c, r;
            c = rnd128(); r = rnd128();
            if (mode == 1) begin c = '1; r = '0; end
            if (mode == 2) r = c;
            if (gaps && ($urandom % 2 == 1))
                drive(1'b0, 1'b1, 3'($urandom), rnd128(), rnd128());  // R8 idle cycle
            // R10: junk shape on non-start rows
            drive(1'b1, k == 0, (k == 0) ? 3'(shape) : 3'($urandom), c, r);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        // R11: outputs quiet in reset
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 4'b0) begin
            fails++;
            $display("FAIL R11 reset valid actual %b expected 0000", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (out_valid !== 4'b0) begin
            fails++;
            $display("FAIL R11 post-reset valid actual %b expected 0000", out_valid);
        end
        // R3 R6: every shape code with random pixels
        cur_req = "R3";
        for (int sh = 0; sh < 8; sh++) begin
            send_mb(sh, 0, 1'b0, 16);
            send_mb(sh, 0, 1'b0, 16);
        end
        // R1 R7: extreme pixel patterns
        cur_req = "R1";
        send_mb(6, 1, 1'b0, 16);
        send_mb(3, 2, 1'b0, 16);
        cur_req = "R7";
        send_mb(0, 1, 1'b0, 16);
        repeat (4) @(negedge clk);
        tests++;
        if (max16 != 65280) begin
            fails++;
            $display("FAIL R7 16x16 max sad actual %0d expected 65280", max16);
        end
        // R8 R10: idle gaps and junk inputs
        cur_req = "R8";
        for (int sh = 0; sh < 8; sh++) send_mb(sh, 0, 1'b1, 16);
        // R9: restart mid-block, then wrap-around without start
        cur_req = "R9";
        send_mb(5, 0, 1'b0, 6);
        send_mb(0, 0, 1'b0, 11);
        send_mb(2, 0, 1'b0, 16);
        for (int k = 0; k < 16; k++) drive(1'b1, 1'b0, 3'd4, rnd128(), rnd128());
        in_valid = 1'b0;
        // R2 R4: back-to-back blocks with random shapes
        cur_req = "R2";
        for (int n = 0; n < 10; n++) send_mb($urandom % 8, 0, 1'b0, 16);
        repeat (6) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule